// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a logical address, made of a segment value and a 16-bit offset, into a 20-bit physical byte address for a memory of 1 MB that is organised in bytes. It keeps four 16-bit segment registers: code, stack, data and extra. For each request it chooses one of them on its own. The choice comes from the kind of access, from whether the offset was built on the base pointer, and from an optional override. The offset arrives already computed. The block only does segment selection, address formation and byte sequencing.

Each accepted request becomes a run of byte-wide memory cycles. A byte access takes one cycle, a word two and a double word four. The byte addresses rise from the formed base address, and the data is in little-endian order. Read bytes are put back together into one result, which is presented with a one-cycle done pulse. Segment registers are loaded through a small write port.

Top module: `seg_addr_unit`

## Requirements
- R1: After a synchronous active-low reset, all four segment registers read as zero, `mem_valid` and `done` are low, and `req_ready` is high.
- R2: The base physical address is the selected segment value multiplied by 16, plus the 16-bit offset.
- R3: Address sums above FFFFFh wrap modulo 2^20, both for the base and for every following byte address of a multi-byte access.
- R4: Segment codes are 0 code, 1 stack, 2 data and 3 extra. Access kinds are 0 fetch, 1 stack and 2 data (3 behaves as data). A fetch always uses the code register, and the override is ignored.
- R5: A stack-kind access always uses the stack register, and both the override and the base-pointer flag are ignored.
- R6: A data access with `req_uses_bp` high uses the stack register unless `ovr_valid` is high, in which case `ovr_sel` chooses the register.
- R7: A data access without the base-pointer flag uses the data register, or the extra register when `req_want_extra` is high. A valid override takes precedence over both.
- R8: A segment write on `seg_wr_*` affects requests accepted from the next cycle on. A request accepted in the same cycle as the write still sees the old value.
- R9: Sizes are 0 byte, 1 word, 2 or 3 double word. An access drives 1, 2 or 4 back-to-back cycles with `mem_valid` high, one byte per cycle, at the base address plus 0, 1, 2 and 3. The first byte cycle is the cycle after acceptance.
- R10: On a write, byte cycle k drives `req_wdata[8k+7:8k]` on `mem_wdata`, with `mem_write` high.
- R11: On a read, `mem_rdata` from byte cycle k lands in `rd_data[8k+7:8k]`. Unused upper bytes are zero. `done` pulses high in the cycle after the last byte cycle, with `rd_data` valid.
- R12: While an access is in progress, `req_ready` is low, and `req_valid` is ignored. The ongoing byte sequence is unaffected and no extra access is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register to write (0 code, 1 stack, 2 data, 3 extra) |
| seg_wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_kind | input | 2 | 0 fetch, 1 stack, 2 data |
| req_uses_bp | input | 1 | Offset was formed with the base pointer |
| req_want_extra | input | 1 | Data access asks for the extra segment |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code |
| req_offset | input | 16 | Offset within the segment |
| req_size | input | 2 | 0 byte, 1 word, 2/3 double word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, little-endian |
| mem_valid | output | 1 | Byte cycle active |
| mem_write | output | 1 | Byte cycle is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Byte written |
| mem_rdata | input | 8 | Byte read, valid in the same cycle |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 32 | Assembled read data |

## Verification
The bench goes after the places where the selection priority matters. It sends fetch and stack requests with an override present, where a design that let the override win would form the address in the wrong segment. It also covers base-pointer data accesses with and without an override, and the extra-segment request beaten by an override. For address formation it uses segment FFFFh with offsets that carry past bit 19, and a double word that crosses FFFFFh. A design that kept the carry, or that did not wrap the later byte addresses, would drive addresses out of range. It also checks a segment load in the same cycle as a request, where a bypassing design would use the new value too early. Finally, it holds `req_valid` high during a transfer to catch a design that restarts or corrupts the byte sequence.

// File: rtl/seg_pkg.sv
// Shared parameters and types for the segmented address generator.
// Assumes four segment registers and little-endian byte ordering.
package seg_pkg;
    localparam int SEG_W     = 16;
    localparam int OFF_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PA_W      = SEG_W + SEG_SHIFT;
    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 4;
    localparam int DATA_W    = MAX_BYTES * BYTE_W;
    localparam int NSEG      = 4;
    localparam int SEL_W     = $clog2(NSEG);
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_STACK = 2'd1,
        SEG_DATA  = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_STACK = 2'd1,
        ACC_DATA  = 2'd2,
        ACC_DATA2 = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_WORD   = 2'd1,
        SZ_DWORD  = 2'd2,
        SZ_DWORD2 = 2'd3
    } acc_size_e;
endpackage

// File: rtl/seg_regfile.sv
// Bank of segment registers with a single write port.
// Assumes a write becomes visible on the output after the clock edge
// that samples it. All registers clear to zero on reset.
module seg_regfile #(
    parameter int SEG_W = 16,
    parameter int NSEG  = 4,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [SEG_W-1:0]           wr_data,
    output logic [NSEG-1:0][SEG_W-1:0] seg_q
);
    logic [SEG_W-1:0] regs [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        // Hold one segment value, replacing it when addressed by the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
        assign seg_q[g] = regs[g];
    end
endmodule

// File: rtl/seg_select.sv
// Chooses the segment register for an access.
// Fetches go to code and stack-kind accesses go to stack, both regardless
// of any override. Data accesses take the override when it is valid.
// Otherwise the base-pointer flag selects stack, the extra request selects
// extra, and the default is data. Purely combinational.
module seg_select
    import seg_pkg::*;
(
    input  acc_kind_e kind,
    input  logic      uses_bp,
    input  logic      want_extra,
    input  logic      ovr_valid,
    input  seg_id_e   ovr_sel,
    output seg_id_e   sel
);
    // Apply the fixed-then-override-then-default priority.
    always_comb begin
        unique case (kind)
            ACC_FETCH: sel = SEG_CODE;
            ACC_STACK: sel = SEG_STACK;
            default: begin
                if (ovr_valid)       sel = ovr_sel;
                else if (uses_bp)    sel = SEG_STACK;
                else if (want_extra) sel = SEG_EXTRA;
                else                 sel = SEG_DATA;
            end
        endcase
    end
endmodule

// File: rtl/addr_former.sv
// Forms a physical address from a segment value and an offset.
// Assumes the result width is SEG_W + SEG_SHIFT, so the carry out of the
// top bit is dropped and the sum wraps.
module addr_former #(
    parameter int SEG_W     = 16,
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PA_W      = SEG_W + SEG_SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  pa
);
    logic [SEG_W+SEG_SHIFT-1:0] seg_base;

    // Scale the segment value to its byte-boundary start address.
    always_comb seg_base = {seg, {SEG_SHIFT{1'b0}}};

    // Add the offset modulo 2^PA_W.
    always_comb pa = PA_W'(seg_base) + PA_W'(off);
endmodule

// File: rtl/byte_sequencer.sv
// Runs one access as a series of byte cycles on a byte-wide memory port.
// Byte k goes to base + k (wrapping), and write bytes are taken lowest
// lane first. Read bytes are gathered into lanes, and done pulses one cycle
// after the last byte. It assumes that memory read data is valid in the
// same cycle as mem_valid, and that start is only raised while idle.
module byte_sequencer #(
    parameter int PA_W      = 20,
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 4,
    localparam int DATA_W   = MAX_BYTES * BYTE_W,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PA_W-1:0]   base,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic              is_write,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [PA_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    logic                              busy_q;
    logic                              done_q;
    logic                              wr_q;
    logic [PA_W-1:0]                   base_q;
    logic [CNT_W-1:0]                  idx_q;
    logic [CNT_W-1:0]                  last_q;
    logic [DATA_W-1:0]                 wbuf_q;
    logic [MAX_BYTES-1:0][BYTE_W-1:0]  rbuf_q;
    logic                              last_byte;

    // Flag the final byte of the current run.
    always_comb last_byte = busy_q && (idx_q == last_q);

    // Control state: launch on start, count bytes, retire on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            wr_q   <= 1'b0;
            base_q <= '0;
            idx_q  <= '0;
            last_q <= '0;
            wbuf_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q && start) begin
                busy_q <= 1'b1;
                base_q <= base;
                idx_q  <= '0;
                last_q <= nbytes - CNT_W'(1);
                wr_q   <= is_write;
                wbuf_q <= wdata;
            end else if (busy_q) begin
                idx_q  <= idx_q + CNT_W'(1);
                wbuf_q <= wbuf_q >> BYTE_W;
                if (last_byte) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Gather read bytes into their lanes, clearing all lanes at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf_q <= '0;
        end else if (!busy_q && start) begin
            rbuf_q <= '0;
        end else if (busy_q) begin
            for (int l = 0; l < MAX_BYTES; l++) begin
                if (idx_q == CNT_W'(l)) rbuf_q[l] <= mem_rdata;
            end
        end
    end

    // Present the memory port and the result.
    always_comb begin
        busy      = busy_q;
        mem_valid = busy_q;
        mem_write = busy_q && wr_q;
        mem_addr  = base_q + PA_W'(idx_q);
        mem_wdata = wbuf_q[BYTE_W-1:0];
        done      = done_q;
        rd_data   = rbuf_q;
    end
endmodule

// File: rtl/seg_addr_unit.sv
// Top level: segment registers, segment choice, address formation and
// byte sequencing. A request is accepted when req_valid and req_ready are
// both high. The segment value is read in the accept cycle, so a write made
// in that same cycle is not yet seen.
module seg_addr_unit
    import seg_pkg::*;
#(
    parameter int P_SEG_W     = SEG_W,
    parameter int P_OFF_W     = OFF_W,
    parameter int P_SEG_SHIFT = SEG_SHIFT,
    parameter int P_MAX_BYTES = MAX_BYTES,
    localparam int LP_PA_W    = P_SEG_W + P_SEG_SHIFT,
    localparam int LP_DATA_W  = P_MAX_BYTES * BYTE_W,
    localparam int LP_CNT_W   = $clog2(P_MAX_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seg_wr_en,
    input  logic [1:0]           seg_wr_sel,
    input  logic [P_SEG_W-1:0]   seg_wr_data,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_kind,
    input  logic                 req_uses_bp,
    input  logic                 req_want_extra,
    input  logic                 ovr_valid,
    input  logic [1:0]           ovr_sel,
    input  logic [P_OFF_W-1:0]   req_offset,
    input  logic [1:0]           req_size,
    input  logic                 req_write,
    input  logic [LP_DATA_W-1:0] req_wdata,
    output logic                 mem_valid,
    output logic                 mem_write,
    output logic [LP_PA_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0]    mem_wdata,
    input  logic [BYTE_W-1:0]    mem_rdata,
    output logic                 done,
    output logic [LP_DATA_W-1:0] rd_data
);
    logic [NSEG-1:0][P_SEG_W-1:0] seg_bank;
    seg_id_e                      seg_pick;
    logic [LP_PA_W-1:0]           base_pa;
    logic [LP_CNT_W-1:0]          nbytes;
    logic                         seq_busy;
    logic                         accept;

    seg_regfile #(.SEG_W(P_SEG_W), .NSEG(NSEG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .seg_q   (seg_bank)
    );

    seg_select u_sel (
        .kind       (acc_kind_e'(req_kind)),
        .uses_bp    (req_uses_bp),
        .want_extra (req_want_extra),
        .ovr_valid  (ovr_valid),
        .ovr_sel    (seg_id_e'(ovr_sel)),
        .sel        (seg_pick)
    );

    addr_former #(
        .SEG_W(P_SEG_W), .OFF_W(P_OFF_W),
        .SEG_SHIFT(P_SEG_SHIFT), .PA_W(LP_PA_W)
    ) u_form (
        .seg (seg_bank[seg_pick]),
        .off (req_offset),
        .pa  (base_pa)
    );

    // Map the size code to a byte count.
    always_comb begin
        unique case (acc_size_e'(req_size))
            SZ_BYTE: nbytes = LP_CNT_W'(1);
            SZ_WORD: nbytes = LP_CNT_W'(2);
            default: nbytes = LP_CNT_W'(P_MAX_BYTES);
        endcase
    end

    // Accept a request only while the sequencer is idle.
    always_comb begin
        req_ready = !seq_busy;
        accept    = req_valid && !seq_busy;
    end

    byte_sequencer #(
        .PA_W(LP_PA_W), .BYTE_W(BYTE_W), .MAX_BYTES(P_MAX_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .base      (base_pa),
        .nbytes    (nbytes),
        .is_write  (req_write),
        .wdata     (req_wdata),
        .busy      (seq_busy),
        .mem_valid (mem_valid),
        .mem_write (mem_write),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .done      (done),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/seg_addr_unit_chk.sv
// Property checker for seg_addr_unit, attached with bind.
// It watches the ports together with the segment bank and the selected segment.
module seg_addr_unit_chk #(
    parameter int SEG_W = 16,
    parameter int NSEG  = 4,
    parameter int PA_W  = 20
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [1:0]                 req_kind,
    input logic [1:0]                 sel,
    input logic                       seg_wr_en,
    input logic [1:0]                 seg_wr_sel,
    input logic [SEG_W-1:0]           seg_wr_data,
    input logic [NSEG-1:0][SEG_W-1:0] seg_q,
    input logic                       mem_valid,
    input logic [PA_W-1:0]            mem_addr,
    input logic                       done
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!mem_valid && !done && req_ready));

    p_fetch_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind == 2'd0) |-> (sel == 2'd0));

    p_stack_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind == 2'd1) |-> (sel == 2'd1));

    p_seg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seg_wr_en |=> (seg_q[$past(seg_wr_sel)] == $past(seg_wr_data)));

    p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && $past(mem_valid)) |-> (mem_addr == $past(mem_addr) + PA_W'(1)));

    p_done_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_valid) && !mem_valid));

    p_busy_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);
endmodule

bind seg_addr_unit seg_addr_unit_chk #(
    .SEG_W(P_SEG_W), .NSEG(4), .PA_W(LP_PA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_kind    (req_kind),
    .sel         (seg_pick),
    .seg_wr_en   (seg_wr_en),
    .seg_wr_sel  (seg_wr_sel),
    .seg_wr_data (seg_wr_data),
    .seg_q       (seg_bank),
    .mem_valid   (mem_valid),
    .mem_addr    (mem_addr),
    .done        (done)
);

// File: tb/tb_seg_addr_unit.sv
// Directed bench for seg_addr_unit. All tasks begin and end at a falling edge.
module tb_seg_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic        req_uses_bp = 1'b0;
    logic        req_want_extra = 1'b0;
    logic        ovr_valid = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic [15:0] req_offset = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        mem_valid;
    logic        mem_write;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        done;
    logic [31:0] rd_data;

    int nchk = 0;
    int nerr = 0;
    logic [15:0] shadow [4];

    always #5 clk = ~clk;

    function automatic logic [7:0] rd_fn(logic [19:0] a);
        return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'hA5;
    endfunction

    assign mem_rdata = rd_fn(mem_addr);

    seg_addr_unit dut (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_uses_bp(req_uses_bp), .req_want_extra(req_want_extra),
        .ovr_valid(ovr_valid), .ovr_sel(ovr_sel), .req_offset(req_offset),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .rd_data(rd_data)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_seg(input logic [1:0] s, input logic [15:0] v);
        seg_wr_en = 1'b1; seg_wr_sel = s; seg_wr_data = v;
        @(posedge clk); @(negedge clk);
        seg_wr_en = 1'b0;
        shadow[s] = v;
    endtask

    // One access; expected base comes from the shadow copy of segment exp_seg.
    task automatic access(input logic [1:0] kind, input logic bp, input logic ext,
                          input logic ov, input logic [1:0] ovs, input logic [15:0] off,
                          input logic [1:0] sz, input logic wr, input logic [31:0] wd,
                          input logic [1:0] exp_seg, input logic hold, input string tag);
        int n;
        logic [19:0] base;
        logic [31:0] exp_rd;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        base = {shadow[exp_seg], 4'h0} + {4'h0, off};
        exp_rd = '0;
        req_valid = 1'b1; req_kind = kind; req_uses_bp = bp; req_want_extra = ext;
        ovr_valid = ov; ovr_sel = ovs; req_offset = off; req_size = sz;
        req_write = wr; req_wdata = wd;
        @(posedge clk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            seg_wr_en = 1'b0;
            if (hold && k < n - 1) begin
                req_offset = 16'h0F0F; req_size = 2'd2; req_kind = 2'd2;
            end else begin
                req_valid = 1'b0;
            end
            check(mem_valid === 1'b1, {tag, " R9 valid"}, 32'(mem_valid), 1);
            check(mem_addr === base + 20'(k), {tag, " R2/R3/R9 addr"},
                  32'(mem_addr), 32'(base + 20'(k)));
            check(req_ready === 1'b0, {tag, " R12 ready low"}, 32'(req_ready), 0);
            check(mem_write === wr, {tag, " R10 write flag"}, 32'(mem_write), 32'(wr));
            if (wr)
                check(mem_wdata === wd[8*k +: 8], {tag, " R10 wdata"},
                      32'(mem_wdata), 32'(wd[8*k +: 8]));
            exp_rd[8*k +: 8] = rd_fn(base + 20'(k));
        end
        @(negedge clk);
        check(done === 1'b1 && mem_valid === 1'b0, {tag, " R11 done"}, 32'(done), 1);
        if (!wr)
            check(rd_data === exp_rd, {tag, " R11 rd_data"}, rd_data, exp_rd);
        @(negedge clk);
        check(done === 1'b0 && mem_valid === 1'b0, {tag, " R12 no extra access"},
              32'({done, mem_valid}), 0);
    endtask

    task automatic t_reset;
        check(req_ready === 1'b1 && mem_valid === 1'b0 && done === 1'b0,
              "R1 idle after reset", 32'({req_ready, mem_valid, done}), 32'b100);
        for (int s = 0; s < 4; s++) shadow[s] = '0;
        access(2'd0, 0, 0, 0, 2'd0, 16'h0000, 2'd0, 0, 0, 2'd0, 0, "R1 code zero");
        access(2'd2, 0, 1, 0, 2'd0, 16'h0042, 2'd0, 0, 0, 2'd3, 0, "R1 extra zero");
    endtask

    task automatic t_basic_addr;
        load_seg(2'd0, 16'h1234);
        load_seg(2'd1, 16'h8000);
        load_seg(2'd2, 16'hA5C3);
        load_seg(2'd3, 16'h0FF0);
        access(2'd0, 0, 0, 0, 2'd0, 16'h5678, 2'd0, 0, 0, 2'd0, 0, "R2 fetch");
        access(2'd2, 0, 0, 0, 2'd0, 16'h0001, 2'd1, 0, 0, 2'd2, 0, "R2 data word");
    endtask

    task automatic t_wrap;
        load_seg(2'd2, 16'hFFFF);
        access(2'd2, 0, 0, 0, 2'd0, 16'h0010, 2'd0, 0, 0, 2'd2, 0, "R3 base wrap");
        access(2'd2, 0, 0, 0, 2'd0, 16'h000E, 2'd2, 0, 0, 2'd2, 0, "R3 dword wrap");
        access(2'd2, 0, 0, 0, 2'd0, 16'hFFFF, 2'd0, 0, 0, 2'd2, 0, "R3 max sum");
    endtask

    task automatic t_fetch_code;
        access(2'd0, 1, 1, 1, 2'd3, 16'h0100, 2'd1, 0, 0, 2'd0, 0, "R4 fetch ignores override");
    endtask

    task automatic t_stack;
        access(2'd1, 0, 0, 1, 2'd2, 16'hFFFE, 2'd1, 1, 32'h0000BEEF, 2'd1, 0,
               "R5 stack ignores override");
        access(2'd1, 1, 1, 0, 2'd0, 16'h0004, 2'd0, 0, 0, 2'd1, 0, "R5 stack with bp");
    endtask

    task automatic t_bp;
        access(2'd2, 1, 0, 0, 2'd0, 16'h0020, 2'd0, 0, 0, 2'd1, 0, "R6 bp to stack");
        access(2'd2, 1, 0, 1, 2'd2, 16'h0020, 2'd0, 0, 0, 2'd2, 0, "R6 bp override");
        access(2'd3, 1, 1, 0, 2'd0, 16'h0030, 2'd0, 0, 0, 2'd1, 0, "R6 kind3 bp");
    endtask

    task automatic t_data_extra;
        load_seg(2'd2, 16'h2222);
        access(2'd2, 0, 0, 0, 2'd0, 16'h0100, 2'd0, 0, 0, 2'd2, 0, "R7 data default");
        access(2'd2, 0, 1, 0, 2'd0, 16'h0100, 2'd0, 0, 0, 2'd3, 0, "R7 extra");
        access(2'd2, 0, 1, 1, 2'd0, 16'h0100, 2'd0, 0, 0, 2'd0, 0, "R7 override beats extra");
    endtask

    task automatic t_load_timing;
        seg_wr_en = 1'b1; seg_wr_sel = 2'd0; seg_wr_data = 16'h4000;
        access(2'd0, 0, 0, 0, 2'd0, 16'h0008, 2'd0, 0, 0, 2'd0, 0, "R8 same cycle old");
        shadow[0] = 16'h4000;
        access(2'd0, 0, 0, 0, 2'd0, 16'h0008, 2'd0, 0, 0, 2'd0, 0, "R8 next cycle new");
    endtask

    task automatic t_write_bytes;
        access(2'd2, 0, 0, 0, 2'd0, 16'h0200, 2'd2, 1, 32'h29561234, 2'd2, 0, "R10 dword write");
        access(2'd2, 0, 0, 0, 2'd0, 16'h0300, 2'd3, 1, 32'hCAFE0B0E, 2'd2, 0, "R10 size3 write");
    endtask

    task automatic t_read_assemble;
        access(2'd2, 0, 0, 0, 2'd0, 16'h0451, 2'd2, 0, 0, 2'd2, 0, "R11 dword read");
        access(2'd2, 0, 0, 0, 2'd0, 16'h0451, 2'd1, 0, 0, 2'd2, 0, "R11 word read");
        access(2'd2, 0, 0, 0, 2'd0, 16'h0777, 2'd0, 0, 0, 2'd2, 0, "R11 byte read");
    endtask

    task automatic t_busy_ignored;
        access(2'd2, 0, 0, 0, 2'd0, 16'h1000, 2'd2, 0, 0, 2'd2, 1, "R12 busy ignored");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready === 1'b1 && mem_valid === 1'b0 && done === 1'b0,
              "R1 during reset", 32'({req_ready, mem_valid, done}), 32'b100);
        rst_n = 1'b1;
        t_reset();
        t_basic_addr();
        t_wrap();
        t_fetch_code();
        t_stack();
        t_bp();
        t_data_extra();
        t_load_timing();
        t_write_bytes();
        t_read_assemble();
        t_busy_ignored();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule